// File: doc/BRIEF.md
# Infrared Receive Pulse Demodulator

This block sits between an infrared receive pin and a standard UART receiver. Infrared links signal a zero as a short active-low pulse, much narrower than a bit period, and a UART cannot sample a pulse that narrow. The block measures every low pulse with a programmable down counter. Pulses that are too short count as glitches and are dropped. A pulse that lasts long enough turns into a low level on the output that lasts exactly one bit time. The UART then samples that level.

The raw pin first passes through a two-stage synchronizer. Edges are found by comparing the current synchronized sample with the previous one. At each falling edge the filter value is captured into an 8-bit counter, and the counter then decrements once per clock. If the line goes high again before the counter reaches zero, the pulse is rejected and the counter reloads. If the counter reaches zero while the line is still low, the pulse is accepted and a 16-bit bit-time counter holds the output low. For the filter to fit inside a standard 1.41 µs infrared pulse, the value must satisfy clock period × (filter value + 3) < 1.41 µs.

Top module: `irda_rx_demod`

## Requirements
- R1: After reset, and whenever no accepted pulse is being stretched, `rxOut` is high (the line idles high).
- R2: With filter value F, an accepted pulse makes `rxOut` go low F+3 clock edges after the first rising clock edge that samples `rxPin` low. This delay covers the two synchronizer stages, the edge detector and the F+1 counter states.
- R3: A low pulse on `rxPin` that lasts F+1 clock cycles or fewer is rejected, and `rxOut` stays high.
- R4: A low pulse on `rxPin` that lasts F+2 clock cycles or more is accepted. This holds at both extremes of the 8-bit filter field, F=0 and F=255.
- R5: Once a pulse is accepted, `rxOut` stays low for exactly D clock cycles, where D is `bitDiv`. A divisor of 0 acts as 1.
- R6: Falling edges that arrive while `rxOut` is low are ignored. A pin that is still low when `rxOut` returns high does not start a new measurement, because a measurement needs a fresh falling edge.
- R7: The filter value is captured at the falling edge. Changing `filtVal` while a pulse is being measured does not change the accept/reject decision for that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxPin | input | 1 | Raw infrared receive line, pulses active low, asynchronous |
| filtVal | input | 8 | Glitch filter threshold F |
| bitDiv | input | 16 | Bit time in clock cycles D |
| rxOut | output | 1 | Demodulated serial line for a UART receiver, idles high |

## Verification
The bench sends pulses exactly one cycle shorter than the threshold and exactly at the threshold, for a mid-range filter value and for both 0 and 255. An off-by-one in the counter compare or in the synchronizer depth would accept the short pulse or reject the long one, and it would also move the measured fall delay. The bench counts the output's low cycles for a normal divisor and for a zero divisor, which catches a stretch one cycle too long or too short. It also drives a second pulse while the output is stretched, and a pulse that outlasts the bit time. A design that does not lock out new edges during the stretch, or that triggers on the low level instead of the edge, would show a second low run or a longer one. Finally, the bench changes the filter value in the middle of a pulse. A design that compares against the live input instead of the captured value would change its accept/reject decision.

// File: rtl/irda_demod_pkg.sv
package irda_demod_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } demodState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic filtLoad;
    logic filtDec;
    logic bitLoad;
    logic bitDec;
    logic outLow;
    logic outHigh;
  } demodStrobe_t;

endpackage

// File: rtl/irda_demod_dp.sv
module irda_demod_dp
  import irda_demod_pkg::*;
#(
  parameter int FILT_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPin,
  input  logic [FILT_W-1:0] filtVal,
  input  logic [DIV_W-1:0]  bitDiv,
  input  demodStrobe_t      str,
  output logic              rxSync,
  output logic              fallEdge,
  output logic              filtZero,
  output logic              bitZero,
  output logic              rxOut
);

  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rxPrev;
  logic [FILT_W-1:0]      filtCnt;
  logic [DIV_W-1:0]       bitCnt;
  logic [DIV_W-1:0]       bitStart;

  // synchronizer chain, idles high
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[gi] <= 1'b1;
        else if (gi == 0) syncChain[gi] <= rxPin;
        else syncChain[gi] <= syncChain[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign rxSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= 1'b1;
    else rxPrev <= rxSync;
  end

  assign fallEdge = rxPrev & ~rxSync;

  // glitch filter down counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) filtCnt <= filtVal;
    else if (str.filtLoad) filtCnt <= filtVal;
    else if (str.filtDec) filtCnt <= filtCnt - 1'b1;
  end

  assign filtZero = (filtCnt == '0);

  // bit-time counter, divisor 0 treated as 1
  assign bitStart = (bitDiv == '0) ? '0 : bitDiv - DIV_ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (str.bitLoad) bitCnt <= bitStart;
    else if (str.bitDec) bitCnt <= bitCnt - DIV_ONE;
  end

  assign bitZero = (bitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxOut <= 1'b1;
    else if (str.outLow) rxOut <= 1'b0;
    else if (str.outHigh) rxOut <= 1'b1;
  end

  // R7: the filter counter steps down by one while measuring
  a_r7_filter_steps: assert property (@(posedge clk) disable iff (!rstN)
    (str.filtDec && !str.filtLoad) |=> (filtCnt == $past(filtCnt) - 1'b1));

  // R5: the last bit-time count releases the output
  a_r5_release_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!rxOut && bitZero && !str.bitLoad) |=> rxOut);

endmodule

// File: rtl/irda_demod_ctrl.sv
module irda_demod_ctrl
  import irda_demod_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxSync,
  input  logic         fallEdge,
  input  logic         filtZero,
  input  logic         bitZero,
  input  logic         rxOut,
  output demodStrobe_t str
);

  demodState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    str      = '0;
    unique case (state)
      ST_IDLE: begin
        str.filtLoad = 1'b1;
        if (fallEdge) stateNxt = ST_COUNT;
      end
      ST_COUNT: begin
        if (rxSync) begin
          stateNxt = ST_IDLE;
        end else if (filtZero) begin
          str.bitLoad = 1'b1;
          str.outLow  = 1'b1;
          stateNxt    = ST_HOLD;
        end else begin
          str.filtDec = 1'b1;
        end
      end
      ST_HOLD: begin
        if (bitZero) begin
          str.outHigh = 1'b1;
          stateNxt    = ST_IDLE;
        end else begin
          str.bitDec = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // R1/R5: the output is low exactly while the stretch is active
  a_r5_low_while_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxOut == (state != ST_HOLD)));

  // R3: the line going high mid-measurement rejects the pulse
  a_r3_reject_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNT && rxSync) |=> (state == ST_IDLE && rxOut));

  // R4: reaching zero with the line low accepts the pulse
  a_r4_accept_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COUNT && !rxSync && filtZero) |=> (state == ST_HOLD && !rxOut));

  // R6: no measurement can start straight out of the stretch
  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |=> (state != ST_COUNT));

endmodule

// File: rtl/irda_rx_demod.sv
module irda_rx_demod
  import irda_demod_pkg::*;
#(
  parameter int FILT_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPin,
  input  logic [FILT_W-1:0] filtVal,
  input  logic [DIV_W-1:0]  bitDiv,
  output logic              rxOut
);

  demodStrobe_t str;
  logic rxSync, fallEdge, filtZero, bitZero;

  irda_demod_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxSync   (rxSync),
    .fallEdge (fallEdge),
    .filtZero (filtZero),
    .bitZero  (bitZero),
    .rxOut    (rxOut),
    .str      (str)
  );

  irda_demod_dp #(
    .FILT_W      (FILT_W),
    .DIV_W       (DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxPin    (rxPin),
    .filtVal  (filtVal),
    .bitDiv   (bitDiv),
    .str      (str),
    .rxSync   (rxSync),
    .fallEdge (fallEdge),
    .filtZero (filtZero),
    .bitZero  (bitZero),
    .rxOut    (rxOut)
  );

endmodule

// File: tb/irda_rx_demod_test.sv
module irda_rx_demod_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxPin = 1'b1;
  logic [7:0]  filtVal = 8'd3;
  logic [15:0] bitDiv = 16'd8;
  logic        rxOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int firstLow, lowCount, lowRuns;

  always #2 clk = ~clk;  // 250 MHz

  irda_rx_demod uut (
    .clk     (clk),
    .rstN    (rstN),
    .rxPin   (rxPin),
    .filtVal (filtVal),
    .bitDiv  (bitDiv),
    .rxOut   (rxOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit pinLevel(input int idx, input int low1, input int gap, input int low2);
    if (idx < low1) return 1'b0;
    if (idx < low1 + gap) return 1'b1;
    if (idx < low1 + gap + low2) return 1'b0;
    return 1'b1;
  endfunction

  // drive low1 / gap / low2 pattern, sample rxOut at each negedge
  task automatic runPattern(input int low1, input int gap, input int low2, input int window,
                            input int chgIdx, input logic [7:0] chgVal);
    bit prev = 1'b1;
    firstLow = -1; lowCount = 0; lowRuns = 0;
    @(negedge clk);
    rxPin = pinLevel(0, low1, gap, low2);
    for (int idx = 0; idx < window; idx++) begin
      @(negedge clk);
      if (rxOut == 1'b0) begin
        lowCount++;
        if (firstLow < 0) firstLow = idx;
        if (prev) lowRuns++;
      end
      prev = rxOut;
      rxPin = pinLevel(idx + 1, low1, gap, low2);
      if (idx == chgIdx) filtVal = chgVal;
    end
    rxPin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1 idle high in reset", int'(rxOut), 1);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle high after reset", int'(rxOut), 1);
  endtask

  task automatic testThreshold(input logic [7:0] f, input int d, input string tag);
    filtVal = f; bitDiv = 16'(d);
    // one cycle short of threshold: rejected
    runPattern(int'(f) + 1, 0, 0, int'(f) + d + 12, -1, 8'd0);
    check({"R3 short pulse rejected ", tag}, lowCount, 0);
    // at threshold: accepted, delay and width
    runPattern(int'(f) + 2, 0, 0, int'(f) + d + 12, -1, 8'd0);
    check({"R4 threshold pulse accepted ", tag}, lowRuns, 1);
    check({"R2 fall delay ", tag}, firstLow, int'(f) + 3);
    check({"R5 low width ", tag}, lowCount, d);
  endtask

  task automatic testZeroDivisor();
    filtVal = 8'd2; bitDiv = 16'd0;
    runPattern(6, 0, 0, 20, -1, 8'd0);
    check("R5 divisor zero acts as one", lowCount, 1);
    check("R2 fall delay divisor zero", firstLow, 5);
  endtask

  task automatic testHoldIgnore();
    filtVal = 8'd3; bitDiv = 16'd40;
    runPattern(5, 3, 8, 80, -1, 8'd0);
    check("R6 second pulse in stretch ignored runs", lowRuns, 1);
    check("R6 second pulse in stretch ignored width", lowCount, 40);
  endtask

  task automatic testLongPulse();
    filtVal = 8'd3; bitDiv = 16'd10;
    runPattern(40, 0, 0, 70, -1, 8'd0);
    check("R6 held-low pin no retrigger runs", lowRuns, 1);
    check("R6 held-low pin no retrigger width", lowCount, 10);
  endtask

  task automatic testFilterChange();
    bitDiv = 16'd6;
    filtVal = 8'd10;
    runPattern(12, 0, 0, 30, 4, 8'd2);
    check("R7 captured filter keeps accept", firstLow, 13);
    filtVal = 8'd10;
    runPattern(11, 0, 0, 30, 4, 8'd2);
    check("R7 captured filter keeps reject", lowCount, 0);
  endtask

  initial begin
    testReset();
    testThreshold(8'd3, 8, "F3");
    testThreshold(8'd0, 5, "F0");
    testThreshold(8'd255, 4, "F255");
    testZeroDivisor();
    testHoldIgnore();
    testLongPulse();
    testFilterChange();
    check("R1 idle high at end", int'(rxOut), 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule